// File: doc/BRIEF.md
# Five-State Irregular Sequence Counter

This block is a 3-bit synchronous counter whose state register walks a fixed loop of five codes that are not in binary order: 000, then 100, then 011, then 001, then 010, and back to 000. All three state bits are updated on the same rising clock edge. The count is presented directly on the output, so a neighbour can decode any of the five codes as a phase marker.

The three codes that the loop never visits (101, 110 and 111) cannot trap the counter. Each of them leads back to 000 on the next enabled edge, so a disturbance in the state register is cleared within one enabled cycle. The next-state function exists in two forms: J-K excitation equations, and a direct table of next codes. A parameter picks which form drives the register. The other form is still built so that the two can be compared on every cycle.

The reset is synchronous and active low, and it wins over the enable. While the enable is low, the register keeps its value, whether that value is in the loop or not.

Top module: `seq5_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` becomes 000 after that edge, whatever `en` is.
- R2: When `rst_n` is high and `en` is low at a rising edge, `count` keeps its value across that edge, including when it holds an unused code.
- R3: With `rst_n` and `en` high, `count` 000 is followed by 100.
- R4: With `rst_n` and `en` high, `count` 100 is followed by 011.
- R5: With `rst_n` and `en` high, `count` 011 is followed by 001.
- R6: With `rst_n` and `en` high, `count` 001 is followed by 010.
- R7: With `rst_n` and `en` high, `count` 010 is followed by 000, which closes the five-state loop.
- R8: With `rst_n` and `en` high, each of the unused codes 101, 110 and 111 is followed by 000.
- R9: The J-K excitation form and the direct table form give the same next code for all eight present codes, so the sequence does not depend on `USE_JK`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all state bits |
| rst_n | input | 1 | Synchronous active-low reset to 000 |
| en | input | 1 | Advance enable; low holds the state |
| count | output | 3 | Present state code |

## Verification
The bench builds the counter with `USE_JK` left at 1, so the J-K equations drive the register. In that build the direct table runs beside the equations, and an embedded check compares the two on every cycle, which covers R9 for every code the register visits. Each unused code is injected into the state register while reset is being released, so the recovery edge and a held edge on an unused code both become reachable. A build with `USE_JK` set to 0 would put the table on the register path and leave the equations as the reference.

// File: rtl/seq5_pkg.sv
// Package: seq5_pkg
// Shared width and state codes of the five-state counter.
// Assumes: the loop order below is the behaviour, so the codes are fixed.
package seq5_pkg;

    localparam int STATE_W = 3;

    typedef logic [STATE_W-1:0] seq5_code_t;

    // Loop members in visiting order.
    localparam seq5_code_t CODE_HOME  = 3'b000;
    localparam seq5_code_t CODE_SECND = 3'b100;
    localparam seq5_code_t CODE_THIRD = 3'b011;
    localparam seq5_code_t CODE_FOURT = 3'b001;
    localparam seq5_code_t CODE_FIFTH = 3'b010;

    // True for the three codes that lie outside the loop.
    function automatic logic is_unused(input seq5_code_t c);
        return (c == 3'b101) || (c == 3'b110) || (c == 3'b111);
    endfunction

endpackage

// File: rtl/seq5_next_table.sv
// Module: seq5_next_table
// Direct next-state function of the five-state loop, written as a table.
// Assumes: any code outside the loop returns to CODE_HOME.
module seq5_next_table
    import seq5_pkg::*;
(
    input  seq5_code_t cur,
    output seq5_code_t nxt
);

    // Map each present code straight onto its successor.
    always_comb begin
        unique case (cur)
            CODE_HOME:  nxt = CODE_SECND;
            CODE_SECND: nxt = CODE_THIRD;
            CODE_THIRD: nxt = CODE_FOURT;
            CODE_FOURT: nxt = CODE_FIFTH;
            CODE_FIFTH: nxt = CODE_HOME;
            default:    nxt = CODE_HOME;
        endcase
    end

endmodule

// File: rtl/seq5_next_jk.sv
// Module: seq5_next_jk
// Next-state function of the five-state loop expressed as J-K excitation.
// The J and K terms were reduced with the unused codes steered to 000;
// each bit then applies the J-K flop rule Q+ = J.~Q | ~K.Q.
// Assumes: bit 2 is the most significant state bit.
module seq5_next_jk
    import seq5_pkg::*;
(
    input  seq5_code_t cur,
    output seq5_code_t nxt
);

    seq5_code_t j_term;
    seq5_code_t k_term;

    // Excitation terms for each flop, derived from the loop and recovery map.
    always_comb begin
        j_term[2] = ~cur[1] & ~cur[0];
        k_term[2] = 1'b1;
        j_term[1] = cur[2] ^ cur[0];
        k_term[1] = 1'b1;
        j_term[0] = cur[2] & ~cur[1];
        k_term[0] = cur[2] | ~cur[1];
    end

    // Apply the J-K characteristic equation to every bit.
    for (genvar b = 0; b < STATE_W; b++) begin : g_jk_bit
        assign nxt[b] = (j_term[b] & ~cur[b]) | (~k_term[b] & cur[b]);
    end

endmodule

// File: rtl/seq5_counter.sv
// Module: seq5_counter
// Three-bit synchronous counter looping 000 -> 100 -> 011 -> 001 -> 010.
// Unused codes return to 000 on the next enabled edge. Reset is synchronous,
// active low, and has priority over the enable.
// Parameter USE_JK selects which next-state form drives the register; the
// other form is kept and compared against it.
module seq5_counter
    import seq5_pkg::*;
#(
    parameter bit USE_JK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    output logic [STATE_W-1:0] count
);

    seq5_code_t state_q;
    seq5_code_t nxt_table;
    seq5_code_t nxt_jk;
    seq5_code_t nxt_sel;

    seq5_next_table u_table (
        .cur (state_q),
        .nxt (nxt_table)
    );

    seq5_next_jk u_jk (
        .cur (state_q),
        .nxt (nxt_jk)
    );

    // Choose the next-state form that feeds the register.
    if (USE_JK) begin : g_sel_jk
        assign nxt_sel = nxt_jk;
    end else begin : g_sel_table
        assign nxt_sel = nxt_table;
    end

    // State register: reset first, then advance when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CODE_HOME;
        end else if (en) begin
            state_q <= nxt_sel;
        end
    end

    assign count = state_q;

    // R1: reset beats an asserted enable.
    assert_reset_clears_R1: assert property (@(posedge clk)
        (!rst_n && en) |=> (count == CODE_HOME));

    // R2: no enable, no movement.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en) |=> $stable(count));

    assert_step_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == CODE_HOME) |=> (count == CODE_SECND));

    assert_step_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == CODE_SECND) |=> (count == CODE_THIRD));

    assert_step_third_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == CODE_THIRD) |=> (count == CODE_FOURT));

    assert_step_fourth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == CODE_FOURT) |=> (count == CODE_FIFTH));

    assert_step_fifth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == CODE_FIFTH) |=> (count == CODE_HOME));

    // R8: an off-loop code is cleared by one enabled edge.
    assert_unused_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_unused(count)) |=> (count == CODE_HOME));

    // R9: both excitation forms agree on the present code.
    assert_forms_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_jk == nxt_table);

endmodule

// File: tb/test_seq5_counter.sv
`timescale 1ns/1ps
// Directed bench for seq5_counter. Inputs change at the falling edge;
// outputs are sampled at the falling edge after the rising edge that moves them.
module test_seq5_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seq5_counter #(.USE_JK(1'b1)) i_seq5_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .count (count)
    );

    // Expected successor, taken from the requirement list.
    function automatic logic [2:0] want_next(input logic [2:0] c);
        case (c)
            3'b000:  return 3'b100;
            3'b100:  return 3'b011;
            3'b011:  return 3'b001;
            3'b001:  return 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    function automatic string tag_for(input logic [2:0] c);
        case (c)
            3'b000:  return "R3 R9";
            3'b100:  return "R4 R9";
            3'b011:  return "R5 R9";
            3'b001:  return "R6 R9";
            3'b010:  return "R7 R9";
            default: return "R8 R9";
        endcase
    endfunction

    task automatic check(input logic [2:0] got, input logic [2:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // One rising edge, then return at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1: reset with enable high still clears the state.
    task automatic t_reset();
        rst_n = 1'b0;
        en    = 1'b1;
        step();
        step();
        check(count, 3'b000, "R1 reset with en high");
    endtask

    // R3..R7: two full laps, every transition checked.
    task automatic t_two_laps();
        logic [2:0] prev;
        rst_n = 1'b1;
        en    = 1'b1;
        for (int i = 0; i < 10; i++) begin
            prev = count;
            step();
            check(count, want_next(prev), tag_for(prev));
        end
    endtask

    // R2: enable low freezes an in-loop state, then the loop resumes.
    task automatic t_hold();
        en = 1'b1;
        step();
        step();                                   // now at 011
        check(count, 3'b011, "R5 setup");
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check(count, 3'b011, "R2 hold in loop");
        end
        en = 1'b1;
        step();
        check(count, 3'b001, "R5 resume after hold");
    endtask

    // R1: reset in the middle of the loop.
    task automatic t_reset_mid();
        rst_n = 1'b0;
        en    = 1'b1;
        step();
        check(count, 3'b000, "R1 mid-loop reset");
        rst_n = 1'b1;
        step();
        check(count, 3'b100, "R3 after reset");
    endtask

    // R8: inject an unused code while reset releases; optionally hold it first (R2).
    task automatic t_unused(input logic [2:0] code, input bit hold_first);
        rst_n = 1'b0;
        en    = 1'b0;
        step();
        force i_seq5_counter.state_q = code;
        rst_n = 1'b1;
        en    = hold_first ? 1'b0 : 1'b1;
        #1;
        release i_seq5_counter.state_q;
        check(count, code, "R8 injected code visible");
        if (hold_first) begin
            step();
            check(count, code, "R2 hold on unused code");
            en = 1'b1;
        end
        step();
        check(count, 3'b000, "R8 recovery to 000");
        step();
        check(count, 3'b100, "R3 loop resumes after recovery");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_two_laps();
        t_hold();
        t_reset_mid();
        t_unused(3'b101, 1'b0);
        t_unused(3'b110, 1'b0);
        t_unused(3'b111, 1'b0);
        t_unused(3'b101, 1'b1);
        t_unused(3'b111, 1'b1);
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule